// File: doc/BRIEF.md
# Sleep-Mode Power Controller

This block takes a microcontroller into its deepest low-power state and brings it back out. When the CPU decodes a sleep instruction it raises a one-cycle sleep request. The controller then parks the external bus. The data lines go low, every bus control strobe goes to its inactive high level, and the address lines hold the last address the CPU issued. One system-clock cycle later the controller closes the system clock gate on the low phase of the clock. Once the always-on slow domain sees that the gate is closed, it drops the main oscillator enable.

Sleep never resumes in place. Three reset-type events wake the device:

- the external reset pin driven low,
- a real-time clock alarm,
- a debug reset command.

Each of them is synchronised into the slow domain, because that is the only clock running during sleep. On a wake the controller reasserts the oscillator enable at once and holds the core reset low. The reset stays low until a parameterised number of slow cycles has passed with no wake source active, which gives the oscillator time to settle. The same reset-delay path is taken at power-on and when the reset pin is pulled while the device is running. A sleep request that arrives while a wake is pending is ignored.

Top module: `sleep_pwr_ctl`

## Requirements
- R1: After `rstN` is released, `coreRstN` is low, `oscEn` is high and `sysClkEn` is high. `coreRstN` rises between STAB_CYCLES-1 and STAB_CYCLES+3 slow-clock cycles after the release.
- R2: While running, the bus outputs follow the CPU (`busAddr`=`cpuAddr`, `busData`=`cpuData`, `busCtrl`=`cpuCtrl`). In the first system-clock cycle after a sampled `sleepReq`, `busData` is all zeros and every bit of `busCtrl` is 1. `busAddr` then equals the `cpuAddr` value presented when `sleepReq` was sampled.
- R3: `sysClkEn` is still high in the first parked cycle. It falls on the falling edge of `sysClk` in the second parked cycle. From then on `sysClkOut` stays low.
- R4: Within six slow-clock cycles after the clock gate closes, `oscEn` goes low. It stays low, and `coreRstN` stays high, while no wake source is active. `oscEn` is never low while `sysClkEn` is high.
- R5: While parked, `busAddr`, `busData` and `busCtrl` keep their parked values even when the CPU bus inputs change.
- R6: Each wake source ends sleep by itself: `wakeExtN` driven low, `wakeRtc` high, or `wakeDbg` high, each held for at least three slow cycles. Within one slow cycle after the source is released, `oscEn` is high and `coreRstN` is low. `oscEn` never rises without `coreRstN` being low.
- R7: After a wake source is released, `coreRstN` stays low for at least STAB_CYCLES slow cycles and rises within STAB_CYCLES+5. `oscEn` stays high while `coreRstN` is low. When `coreRstN` rises, the system clock is enabled and the bus follows the CPU again.
- R8: A `sleepReq` raised while a wake source is active, or while the reset delay is running, has no effect. The bus is not parked, `sysClkEn` stays high and `oscEn` stays high.
- R9: Pulling `wakeExtN` low while the device is running, with no sleep requested, also drives `coreRstN` low and restarts the reset delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running main oscillator clock (ungated) |
| slowClk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| sleepReq | input | 1 | Sleep request strobe from the CPU decode, sysClk domain |
| wakeExtN | input | 1 | External reset pin, active low wake |
| wakeRtc | input | 1 | Real-time clock alarm wake, active high |
| wakeDbg | input | 1 | Debug reset command wake, active high |
| cpuAddr | input | ADDR_W | Address from the CPU |
| cpuData | input | DATA_W | Data from the CPU |
| cpuCtrl | input | CS_W+6 | Bus control strobes from the CPU, active low |
| busAddr | output | ADDR_W | Address bus to the pins |
| busData | output | DATA_W | Data bus to the pins |
| busCtrl | output | CS_W+6 | Control strobes to the pins |
| sysClkEn | output | 1 | System clock gate enable, changes on the falling edge of sysClk |
| sysClkOut | output | 1 | Gated system clock |
| oscEn | output | 1 | Main oscillator enable |
| coreRstN | output | 1 | Core reset, active low |

## Verification
The sleep path is first run while the CPU drives a non-idle bus. The bus inputs are then changed during sleep, which separates real parking and address holding from a simple pass-through. Every wake source is tried alone, with an alarm pulse, a debug pulse and a long external reset, to show that each one independently leaves sleep through reset. The reset length is measured against the window for each case, which separates a delay counted from the release of the source from a fixed or missing one. A sleep request made while an alarm is held and another made during the delay show that a pending wake overrides sleep. An external reset taken while running shows that the delay path does not depend on having been asleep.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    SYS_RUN  = 2'd0,
    SYS_PARK = 2'd1,
    SYS_GATE = 2'd2
  } sysState_t;

  typedef enum logic [1:0] {
    LP_ACTIVE = 2'd0,
    LP_ASLEEP = 2'd1,
    LP_STAB   = 2'd2
  } lpState_t;

  typedef struct packed {
    logic park;         // drive bus to parked levels
    logic captureAddr;  // track the address the CPU issues
    logic cntClear;     // restart the stabilization count
    logic cntStep;      // advance the stabilization count
  } ctlStrb_t;

  localparam int NUM_WAKE = 3;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     sysClk,
  input  logic     slowClk,
  input  logic     rstN,
  input  logic     sleepReq,
  input  logic     wakeExtN,
  input  logic     wakeRtc,
  input  logic     wakeDbg,
  input  logic     cntDone,
  output ctlStrb_t strb,
  output logic     sysClkEn,
  output logic     sysClkOut,
  output logic     oscEn,
  output logic     coreRstN
);

  sysState_t sysState;
  lpState_t  lpState;
  logic      inStab;
  logic      inStabS;
  logic      sleepGo;
  logic      sleepGoS;
  logic      clkEnReq;
  logic      gateEnQ;
  logic      wakeAny;
  logic [NUM_WAKE-1:0] wakeRaw;
  logic [NUM_WAKE-1:0] wakeS;

  // ---------------- system clock side ----------------
  assign inStab = (lpState == LP_STAB);

  bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stabSync (
    .clk(sysClk), .rstN(rstN), .d(inStab), .q(inStabS)
  );

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      sysState <= SYS_RUN;
    end else begin
      case (sysState)
        SYS_RUN:  if (sleepReq && !inStabS) sysState <= SYS_PARK;
        SYS_PARK: sysState <= inStabS ? SYS_RUN : SYS_GATE;
        SYS_GATE: if (inStabS) sysState <= SYS_RUN;
        default:  sysState <= SYS_RUN;
      endcase
    end
  end

  assign clkEnReq = (sysState != SYS_GATE);

  // gate enable changes only while the clock is low
  always_ff @(negedge sysClk or negedge rstN) begin
    if (!rstN) gateEnQ <= 1'b1;
    else       gateEnQ <= clkEnReq;
  end

  assign sysClkEn  = gateEnQ;
  assign sysClkOut = sysClk & gateEnQ;
  assign sleepGo   = (sysState == SYS_GATE);

  // ---------------- always-on slow side ----------------
  bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_goSync (
    .clk(slowClk), .rstN(rstN), .d(sleepGo), .q(sleepGoS)
  );

  assign wakeRaw = {~wakeExtN, wakeRtc, wakeDbg};

  for (genvar w = 0; w < NUM_WAKE; w++) begin : g_wakeSync
    bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
      .clk(slowClk), .rstN(rstN), .d(wakeRaw[w]), .q(wakeS[w])
    );
  end

  assign wakeAny = |wakeS;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      lpState <= LP_STAB;
    end else begin
      case (lpState)
        LP_ACTIVE: begin
          if (wakeAny)       lpState <= LP_STAB;
          else if (sleepGoS) lpState <= LP_ASLEEP;
        end
        LP_ASLEEP: if (wakeAny) lpState <= LP_STAB;
        LP_STAB:   if (!wakeAny && cntDone) lpState <= LP_ACTIVE;
        default:   lpState <= LP_STAB;
      endcase
    end
  end

  assign oscEn    = (lpState != LP_ASLEEP);
  assign coreRstN = (lpState != LP_STAB);

  always_comb begin
    strb.park        = (sysState != SYS_RUN);
    strb.captureAddr = (sysState == SYS_RUN);
    strb.cntClear    = (lpState != LP_STAB) || wakeAny;
    strb.cntStep     = (lpState == LP_STAB);
  end

endmodule

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int CTRL_W      = 10,
  parameter int STAB_CYCLES = 1024
) (
  input  logic              sysClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [CTRL_W-1:0] cpuCtrl,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic [CTRL_W-1:0] busCtrl,
  output logic              cntDone
);

  localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  logic [ADDR_W-1:0] addrHold;
  logic [CNT_W-1:0]  stabCnt;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                 addrHold <= '0;
    else if (strb.captureAddr) addrHold <= cpuAddr;
  end

  always_comb begin
    if (strb.park) begin
      busAddr = addrHold;
      busData = '0;
      busCtrl = '1;
    end else begin
      busAddr = cpuAddr;
      busData = cpuData;
      busCtrl = cpuCtrl;
    end
  end

  assign cntDone = (stabCnt == CNT_LAST);

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN)                         stabCnt <= '0;
    else if (strb.cntClear)            stabCnt <= '0;
    else if (strb.cntStep && !cntDone) stabCnt <= stabCnt + 1'b1;
  end

endmodule

// File: rtl/sleep_pwr_ctl.sv
module sleep_pwr_ctl
  import sleep_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int CS_W        = 4,
  parameter int STAB_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                slowClk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                wakeExtN,
  input  logic                wakeRtc,
  input  logic                wakeDbg,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuData,
  input  logic [CS_W+5:0]     cpuCtrl,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busData,
  output logic [CS_W+5:0]     busCtrl,
  output logic                sysClkEn,
  output logic                sysClkOut,
  output logic                oscEn,
  output logic                coreRstN
);

  localparam int CTRL_W = CS_W + 6;

  ctlStrb_t ctlStrb;
  logic     cntDone;

  sleep_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .sysClk(sysClk), .slowClk(slowClk), .rstN(rstN),
    .sleepReq(sleepReq), .wakeExtN(wakeExtN), .wakeRtc(wakeRtc),
    .wakeDbg(wakeDbg), .cntDone(cntDone), .strb(ctlStrb),
    .sysClkEn(sysClkEn), .sysClkOut(sysClkOut), .oscEn(oscEn),
    .coreRstN(coreRstN)
  );

  sleep_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .STAB_CYCLES(STAB_CYCLES)
  ) u_dp (
    .sysClk(sysClk), .slowClk(slowClk), .rstN(rstN), .strb(ctlStrb),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuCtrl(cpuCtrl),
    .busAddr(busAddr), .busData(busData), .busCtrl(busCtrl),
    .cntDone(cntDone)
  );

endmodule

// File: rtl/sleep_pwr_ctl_chk.sv
module sleep_pwr_ctl_chk
  import sleep_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              sysClk,
  input logic              slowClk,
  input logic              rstN,
  input ctlStrb_t          strb,
  input logic [ADDR_W-1:0] busAddr,
  input logic              sysClkEn,
  input logic              oscEn,
  input logic              coreRstN
);

  AST_PARK_BEFORE_GATE: assert property (@(posedge sysClk) disable iff (!rstN)
    $fell(sysClkEn) |-> (strb.park && $past(strb.park))); // R3

  AST_ADDR_HELD: assert property (@(posedge sysClk) disable iff (!rstN)
    (strb.park && $past(strb.park)) |-> $stable(busAddr)); // R5

  AST_OSC_OFF_CLK_OFF: assert property (@(posedge slowClk) disable iff (!rstN)
    !oscEn |-> !sysClkEn); // R4

  AST_WAKE_AS_RESET: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(oscEn) |-> !coreRstN); // R6

  AST_OSC_DURING_DELAY: assert property (@(posedge slowClk) disable iff (!rstN)
    !coreRstN |-> oscEn); // R7

endmodule

bind sleep_pwr_ctl sleep_pwr_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .sysClk(sysClk), .slowClk(slowClk), .rstN(rstN), .strb(ctlStrb),
  .busAddr(busAddr), .sysClkEn(sysClkEn), .oscEn(oscEn), .coreRstN(coreRstN)
);

// File: tb/sleep_pwr_ctl_bench.sv
`timescale 1ns/100ps
module sleep_pwr_ctl_bench;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int CS_W   = 4;
  localparam int CTRL_W = CS_W + 6;
  localparam int STAB   = 12;

  logic sysClk = 1'b0;
  logic slowClk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeExtN = 1'b1;
  logic wakeRtc = 1'b0;
  logic wakeDbg = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = 24'h001000;
  logic [DATA_W-1:0] cpuData = 8'hA5;
  logic [CTRL_W-1:0] cpuCtrl = 10'h155;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;
  logic [CTRL_W-1:0] busCtrl;
  logic sysClkEn, sysClkOut, oscEn, coreRstN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  sleep_pwr_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W), .STAB_CYCLES(STAB)
  ) u_sleep_pwr_ctl (
    .sysClk(sysClk), .slowClk(slowClk), .rstN(rstN), .sleepReq(sleepReq),
    .wakeExtN(wakeExtN), .wakeRtc(wakeRtc), .wakeDbg(wakeDbg),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuCtrl(cpuCtrl),
    .busAddr(busAddr), .busData(busData), .busCtrl(busCtrl),
    .sysClkEn(sysClkEn), .sysClkOut(sysClkOut), .oscEn(oscEn),
    .coreRstN(coreRstN)
  );

  always #2 sysClk = ~sysClk;
  initial begin
    #20.5;
    forever begin
      slowClk = ~slowClk;
      #20.5;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sysTick();
    @(posedge sysClk);
    #1;
  endtask

  task automatic slowTick();
    @(posedge slowClk);
    #5;
  endtask

  // count slow cycles until coreRstN rises
  task automatic waitRelease(output int n);
    n = -1;
    for (int i = 1; i <= STAB + 40; i++) begin
      slowTick();
      if (coreRstN) begin
        n = i;
        break;
      end
      chk(oscEn == 1'b1, "R7 oscEn during delay", 32'(oscEn), 1);
    end
  endtask

  task automatic checkRunning(input string req);
    chk(sysClkEn == 1'b1, req, 32'(sysClkEn), 1);
    chk(busData == cpuData && busCtrl == cpuCtrl && busAddr == cpuAddr, req,
        {busData, busCtrl[7:0], 16'h0}, {cpuData, cpuCtrl[7:0], 16'h0});
  endtask

  task automatic tReset();
    int n;
    #100 rstN = 1'b1;
    n = 0;
    for (int i = 1; i <= STAB + 20; i++) begin
      slowTick();
      if (i == 1) begin
        chk(coreRstN == 1'b0, "R1 coreRstN low", 32'(coreRstN), 0);
        chk(oscEn == 1'b1, "R1 oscEn high", 32'(oscEn), 1);
        chk(sysClkEn == 1'b1, "R1 sysClkEn high", 32'(sysClkEn), 1);
      end
      if (coreRstN) begin
        n = i;
        break;
      end
    end
    chk(n >= STAB - 1 && n <= STAB + 3, "R1 delay length", 32'(n), STAB);
  endtask

  task automatic tPassThrough();
    sysTick();
    cpuAddr = 24'h0ABCDE; cpuData = 8'h3C; cpuCtrl = 10'h2AA;
    sysTick();
    checkRunning("R2 pass-through");
  endtask

  task automatic tEnterSleep(input logic [ADDR_W-1:0] addr);
    sysTick();
    cpuAddr = addr; cpuData = 8'h5A; cpuCtrl = 10'h0F0; sleepReq = 1'b1;
    sysTick();
    sleepReq = 1'b0;
    cpuAddr = addr ^ 24'hFFFFFF;
    chk(busData == '0, "R2 data parked low", 32'(busData), 0);
    chk(busCtrl == '1, "R2 ctrl parked high", 32'(busCtrl), 32'h3FF);
    chk(busAddr == addr, "R2 address held", 32'(busAddr), 32'(addr));
    chk(sysClkEn == 1'b1, "R3 clock still on in first parked cycle",
        32'(sysClkEn), 1);
    sysTick();
    sysTick();
    chk(sysClkEn == 1'b0, "R3 clock gated", 32'(sysClkEn), 0);
    chk(sysClkOut == 1'b0, "R3 gated clock low while sysClk high",
        32'(sysClkOut), 0);
    cpuData = 8'hFF; cpuCtrl = 10'h000;
    for (int i = 0; i < 6; i++) slowTick();
    chk(oscEn == 1'b0, "R4 oscillator off", 32'(oscEn), 0);
    chk(coreRstN == 1'b1, "R4 no reset while asleep", 32'(coreRstN), 1);
    chk(busAddr == addr && busData == '0 && busCtrl == '1, "R5 stays parked",
        32'(busAddr), 32'(addr));
    chk(sysClkOut == 1'b0, "R3 gated clock quiet", 32'(sysClkOut), 0);
  endtask

  // src: 0 ext pin, 1 rtc alarm, 2 debug
  task automatic tWake(input int src, input int holdCycles, input string req);
    int n;
    slowTick();
    if (src == 0) wakeExtN = 1'b0;
    else if (src == 1) wakeRtc = 1'b1;
    else wakeDbg = 1'b1;
    for (int i = 0; i < holdCycles; i++) slowTick();
    wakeExtN = 1'b1; wakeRtc = 1'b0; wakeDbg = 1'b0;
    slowTick();
    chk(oscEn == 1'b1, {req, " oscEn back on"}, 32'(oscEn), 1);
    chk(coreRstN == 1'b0, {req, " core in reset"}, 32'(coreRstN), 0);
    waitRelease(n);
    chk(n >= STAB - 1 && n <= STAB + 4, "R7 delay length after release",
        32'(n + 1), STAB);
    cpuAddr = 24'h000123; cpuData = 8'h77; cpuCtrl = 10'h1E1;
    #2;
    checkRunning("R7 running after delay");
  endtask

  task automatic tIgnoreSleep();
    int n;
    slowTick();
    wakeRtc = 1'b1;
    for (int i = 0; i < 5; i++) slowTick();
    sysTick();
    sleepReq = 1'b1;
    sysTick();
    sleepReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sysTick();
      checkRunning("R8 sleep ignored while wake held");
    end
    wakeRtc = 1'b0;
    for (int i = 0; i < 4; i++) slowTick();
    chk(coreRstN == 1'b0, "R8 still in delay", 32'(coreRstN), 0);
    sysTick();
    sleepReq = 1'b1;
    sysTick();
    sleepReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sysTick();
      checkRunning("R8 sleep ignored during delay");
    end
    chk(oscEn == 1'b1, "R8 oscEn stays on", 32'(oscEn), 1);
    waitRelease(n);
    chk(n > 0, "R8 delay ends", 32'(n), 1);
    for (int i = 0; i < 4; i++) slowTick();
    chk(oscEn == 1'b1, "R8 no late sleep entry", 32'(oscEn), 1);
    checkRunning("R8 running after ignored request");
  endtask

  task automatic tResetWhileRunning();
    int n;
    slowTick();
    wakeExtN = 1'b0;
    for (int i = 0; i < 4; i++) slowTick();
    chk(coreRstN == 1'b0, "R9 reset while running", 32'(coreRstN), 0);
    chk(oscEn == 1'b1, "R9 oscEn stays on", 32'(oscEn), 1);
    wakeExtN = 1'b1;
    waitRelease(n);
    chk(n >= STAB && n <= STAB + 5, "R9 delay restarted", 32'(n), STAB);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tReset();
    tPassThrough();
    tEnterSleep(24'h00C0DE);
    tWake(1, 3, "R6 rtc wake");
    tEnterSleep(24'h12F00D);
    tWake(2, 3, "R6 debug wake");
    tEnterSleep(24'hFEDCBA);
    tWake(0, 10, "R6 ext pin wake");
    tIgnoreSleep();
    tResetWhileRunning();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule